// File: doc/BRIEF.md
# Register Rename Map with Physical Tag Free List

This block renames one instruction per clock. It translates the logical register numbers of an instruction into physical register tags. It keeps one table entry per logical register, giving the physical tag that holds that register's newest value. It also keeps a circular list of physical tags that are not in use. On a rename it looks up both source operands in the table, takes the oldest free tag for the destination, and points the destination's entry at that tag. The tag that the destination displaced is reported on a port, so that a later retirement stage can hand it back through the release port once no older reader needs it.

Giving each new write a fresh physical register removes write-after-write and write-after-read conflicts between instructions that name the same logical register. A downstream scheduler sees only the true read-after-write links, which are carried by the tags.

When no tag is free the block raises its stall flag. Renames that need a destination are then refused, and nothing inside the block changes. Renames without a destination still translate their sources.

Top module: `rename_map_unit`

## Requirements
- R1: After reset, logical register i maps to physical tag i for every i in 0 to 7.
- R2: After reset, the free list holds tags 8 to 15, and the first eight allocations return them in ascending order.
- R3: `src_a_tag` and `src_b_tag` show the mapping that is current before this cycle's update. An instruction whose source equals its own destination reads the old tag.
- R4: An accepted rename with a destination returns the oldest free tag on `dst_tag`. From the next cycle on, the destination's entry reads back that tag, and the free list is one entry shorter.
- R5: `prev_tag` shows the tag that the destination logical register held before the rename.
- R6: Released tags join the tail of the free list and are allocated only after every tag already on the list, in release order.
- R7: `stall` is 1 exactly when the free list is empty. While it is 1, a rename with a destination gives `ren_fire` = 0 and changes neither the table nor the list.
- R8: A rename with `ren_dst_en` = 0 gives `ren_fire` = 1 even when the list is empty. It leaves the free list and the table unchanged.
- R9: `ren_fire` is 1 exactly when `ren_valid` is 1 and the rename is not blocked by R7.
- R10: A tag released into an empty list cannot be allocated in the same cycle. `stall` drops in the following cycle, and that tag is allocated next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | A rename request is present |
| ren_src_a | input | 3 | First source logical register |
| ren_src_b | input | 3 | Second source logical register |
| ren_dst_en | input | 1 | The instruction writes a destination |
| ren_dst | input | 3 | Destination logical register |
| rel_valid | input | 1 | Return a physical tag to the free list |
| rel_tag | input | 4 | Physical tag being returned |
| src_a_tag | output | 4 | Physical tag for the first source |
| src_b_tag | output | 4 | Physical tag for the second source |
| dst_tag | output | 4 | Newly allocated tag (0 when no allocation) |
| prev_tag | output | 4 | Tag previously mapped to the destination |
| ren_fire | output | 1 | The rename is accepted this cycle |
| stall | output | 1 | The free list is empty |

## Verification
The hardest state to reach from the ports is a release that arrives while the free list is empty and, in the same cycle, a rename that wants a destination. This requires allocating all eight spare tags first, with no release in between. The stimulus does that by renaming each logical register once. It then tries an allocation while the list is empty, releases into the empty list, and sends a combined release and rename. A long random phase follows. In it, the displaced tags are recycled in a shuffled release order, which exercises wrap-around of the list. A queue-based model checks every cycle of this phase.

// File: rtl/rename_pkg.sv
package rename_pkg;
   localparam int unsigned ARCH_REGS_DFLT = 8;
   localparam int unsigned PHYS_REGS_DFLT = 16;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/rmu_map_table.sv
module rmu_map_table #(
   parameter int unsigned ENTRIES  = rename_pkg::ARCH_REGS_DFLT,
   parameter int unsigned TAG_W    = 4,
   parameter int unsigned RD_PORTS = 3,
   parameter int unsigned AW       = rename_pkg::idx_width(ENTRIES)
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [RD_PORTS-1:0][AW-1:0]        rd_addr,
   output logic [RD_PORTS-1:0][TAG_W-1:0]     rd_tag,
   input  logic                               wr_en,
   input  logic [AW-1:0]                      wr_addr,
   input  logic [TAG_W-1:0]                   wr_tag
);
   if (ENTRIES != (1 << AW)) begin : g_bad_entries
      $error("rmu_map_table: ENTRIES must be a power of two");
   end
   if (ENTRIES > (1 << TAG_W)) begin : g_bad_tag
      $error("rmu_map_table: TAG_W too narrow for identity reset");
   end

   logic [TAG_W-1:0] entry_q [ENTRIES];

   // identity mapping at reset; one write port
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int e = 0; e < ENTRIES; e++) entry_q[e] <= TAG_W'(e);
      end else if (wr_en) begin
         entry_q[wr_addr] <= wr_tag;
      end
   end

   // independent asynchronous read ports
   for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
      assign rd_tag[p] = entry_q[rd_addr[p]];
   end

   // R4: a written entry reads back the written tag next cycle
   assert_map_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> entry_q[$past(wr_addr)] == $past(wr_tag));
endmodule

// File: rtl/rmu_free_fifo.sv
module rmu_free_fifo #(
   parameter int unsigned DEPTH     = 8,
   parameter int unsigned TAG_W     = 4,
   parameter int unsigned FIRST_TAG = 8,
   parameter int unsigned CNT_W     = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pop,
   input  logic               push,
   input  logic [TAG_W-1:0]   push_tag,
   output logic [TAG_W-1:0]   head_tag,
   output logic               empty,
   output logic [CNT_W-1:0]   count
);
   localparam int unsigned PTR_W = rename_pkg::idx_width(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("rmu_free_fifo: DEPTH must be at least 2");
   end
   if (FIRST_TAG + DEPTH > (1 << TAG_W)) begin : g_bad_range
      $error("rmu_free_fifo: initial tags exceed TAG_W");
   end

   logic [TAG_W-1:0] slot_q [DEPTH];
   logic [PTR_W-1:0] head_q, tail_q;
   logic [CNT_W-1:0] count_q;
   logic             full;
   logic             pop_ok, push_ok;

   function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign empty   = (count_q == '0);
   assign full    = (count_q == CNT_W'(DEPTH));
   assign pop_ok  = pop && !empty;
   assign push_ok = push && (!full || pop_ok);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) slot_q[k] <= TAG_W'(FIRST_TAG + k);
      end else if (push_ok) begin
         slot_q[tail_q] <= push_tag;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q  <= '0;
         tail_q  <= '0;
         count_q <= CNT_W'(DEPTH);
      end else begin
         if (pop_ok)  head_q <= ptr_next(head_q);
         if (push_ok) tail_q <= ptr_next(tail_q);
         unique case ({push_ok, pop_ok})
            2'b10:   count_q <= count_q + 1'b1;
            2'b01:   count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
      end
   end

   assign head_tag = slot_q[head_q];
   assign count    = count_q;

   // R6: a release never lands on a full list
   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full) |-> pop);
   // R7: the allocator never asks an empty list
   assert_no_pop_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
   // R6: head and tail meet only when the list is empty or full
   assert_ptr_meet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (head_q == tail_q) |-> (empty || full));
endmodule

// File: rtl/rename_map_unit.sv
module rename_map_unit #(
   parameter int unsigned ARCH_REGS = rename_pkg::ARCH_REGS_DFLT,
   parameter int unsigned PHYS_REGS = rename_pkg::PHYS_REGS_DFLT,
   parameter int unsigned AW        = rename_pkg::idx_width(ARCH_REGS),
   parameter int unsigned PW        = rename_pkg::idx_width(PHYS_REGS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ren_valid,
   input  logic [AW-1:0] ren_src_a,
   input  logic [AW-1:0] ren_src_b,
   input  logic          ren_dst_en,
   input  logic [AW-1:0] ren_dst,
   input  logic          rel_valid,
   input  logic [PW-1:0] rel_tag,
   output logic [PW-1:0] src_a_tag,
   output logic [PW-1:0] src_b_tag,
   output logic [PW-1:0] dst_tag,
   output logic [PW-1:0] prev_tag,
   output logic          ren_fire,
   output logic          stall
);
   localparam int unsigned FREE_DEPTH = PHYS_REGS - ARCH_REGS;
   localparam int unsigned CNT_W      = $clog2(FREE_DEPTH + 1);
   localparam int unsigned RD_PORTS   = 3;

   if (PHYS_REGS <= ARCH_REGS) begin : g_bad_pool
      $error("rename_map_unit: PHYS_REGS must exceed ARCH_REGS");
   end

   logic [RD_PORTS-1:0][AW-1:0] rd_addr;
   logic [RD_PORTS-1:0][PW-1:0] rd_tag;
   logic [PW-1:0]               head_tag;
   logic                        free_empty;
   logic [CNT_W-1:0]            free_count;
   logic                        alloc;

   assign rd_addr  = {ren_dst, ren_src_b, ren_src_a};
   assign alloc    = ren_valid && ren_dst_en && !free_empty;
   assign ren_fire = ren_valid && (!ren_dst_en || !free_empty);
   assign stall    = free_empty;

   rmu_map_table #(
      .ENTRIES (ARCH_REGS),
      .TAG_W   (PW),
      .RD_PORTS(RD_PORTS),
      .AW      (AW)
   ) u_map (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_addr(rd_addr),
      .rd_tag (rd_tag),
      .wr_en  (alloc),
      .wr_addr(ren_dst),
      .wr_tag (head_tag)
   );

   rmu_free_fifo #(
      .DEPTH    (FREE_DEPTH),
      .TAG_W    (PW),
      .FIRST_TAG(ARCH_REGS),
      .CNT_W    (CNT_W)
   ) u_free (
      .clk     (clk),
      .rst_n   (rst_n),
      .pop     (alloc),
      .push    (rel_valid),
      .push_tag(rel_tag),
      .head_tag(head_tag),
      .empty   (free_empty),
      .count   (free_count)
   );

   assign src_a_tag = rd_tag[0];
   assign src_b_tag = rd_tag[1];
   assign prev_tag  = rd_tag[2];
   assign dst_tag   = alloc ? head_tag : '0;

   // R7: an empty list with no release stays empty
   assert_empty_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && !rel_valid) |=> stall);
   // R8: a rename without destination leaves the list length alone
   assert_nodst_keeps_list_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ren_valid && !ren_dst_en && !rel_valid) |=> $stable(free_count));
   // R4: an allocation shortens the list by one
   assert_alloc_shrinks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ren_fire && ren_dst_en && !rel_valid) |=> free_count == $past(free_count) - 1'b1);
   // R10: a release into an empty list clears the stall next cycle
   assert_release_unstalls_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && rel_valid) |=> !stall);
endmodule

// File: tb/rename_map_unit_tb.sv
module rename_map_unit_tb;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       ren_valid, ren_dst_en, rel_valid;
   logic [2:0] ren_src_a, ren_src_b, ren_dst;
   logic [3:0] rel_tag;
   logic [3:0] src_a_tag, src_b_tag, dst_tag, prev_tag;
   logic       ren_fire, stall;

   always #4 clk = ~clk;

   rename_map_unit u_dut (
      .clk(clk), .rst_n(rst_n),
      .ren_valid(ren_valid), .ren_src_a(ren_src_a), .ren_src_b(ren_src_b),
      .ren_dst_en(ren_dst_en), .ren_dst(ren_dst),
      .rel_valid(rel_valid), .rel_tag(rel_tag),
      .src_a_tag(src_a_tag), .src_b_tag(src_b_tag), .dst_tag(dst_tag),
      .prev_tag(prev_tag), .ren_fire(ren_fire), .stall(stall)
   );

   int n_checks = 0;
   int n_fail   = 0;
   int mdl_map[8];
   int free_q[$];
   int hold_q[$];
   int s_a, s_b, s_dst, s_prev, s_fire, s_stall;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one clock: drive at negedge, compare before the edge, advance the model at the edge
   task automatic step(input bit v, input int a, input int b, input bit de, input int d,
                       input bit rv, input int rt);
      int e_fire, e_stall, e_new, e_prev;
      ren_valid = v; ren_src_a = 3'(a); ren_src_b = 3'(b);
      ren_dst_en = de; ren_dst = 3'(d); rel_valid = rv; rel_tag = 4'(rt);
      #2;
      e_stall = (free_q.size() == 0);
      e_fire  = v && (!de || !e_stall);
      s_a = int'(src_a_tag); s_b = int'(src_b_tag); s_dst = int'(dst_tag);
      s_prev = int'(prev_tag); s_fire = int'(ren_fire); s_stall = int'(stall);
      chk(s_stall == e_stall, "R7 stall", s_stall, e_stall);
      chk(s_fire == e_fire, "R9 fire", s_fire, e_fire);
      if (v) begin
         chk(s_a == mdl_map[a], "R3 src_a", s_a, mdl_map[a]);
         chk(s_b == mdl_map[b], "R3 src_b", s_b, mdl_map[b]);
      end
      e_new = 0; e_prev = 0;
      if (e_fire && de) begin
         e_new = free_q[0]; e_prev = mdl_map[d];
         chk(s_dst == e_new, "R4 dst_tag", s_dst, e_new);
         chk(s_prev == e_prev, "R5 prev_tag", s_prev, e_prev);
      end
      @(posedge clk);
      if (e_fire && de) begin
         void'(free_q.pop_front());
         mdl_map[d] = e_new;
         hold_q.push_back(e_prev);
      end
      if (rv) free_q.push_back(rt);
      @(negedge clk);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; ren_valid = 0; ren_dst_en = 0; rel_valid = 0;
      ren_src_a = 0; ren_src_b = 0; ren_dst = 0; rel_tag = 0;
      for (int i = 0; i < 8; i++) mdl_map[i] = i;
      for (int t = 8; t < 16; t++) free_q.push_back(t);
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      chk(stall == 1'b0, "R1 reset stall", int'(stall), 0);
      chk(ren_fire == 1'b0, "R1 reset fire", int'(ren_fire), 0);

      // R1: identity mapping, read-only renames
      for (int i = 0; i < 8; i++) begin
         step(1, i, 7 - i, 0, 0, 0, 0);
         chk(s_a == i, "R1 identity a", s_a, i);
         chk(s_b == 7 - i, "R1 identity b", s_b, 7 - i);
      end

      // R2/R3/R5: rename each register as its own source
      for (int k = 0; k < 8; k++) begin
         step(1, k, (k + 1) % 8, 1, k, 0, 0);
         chk(s_dst == 8 + k, "R2 ascending alloc", s_dst, 8 + k);
         chk(s_a == k, "R3 old source tag", s_a, k);
         chk(s_prev == k, "R5 displaced tag", s_prev, k);
      end
      step(1, 2, 5, 0, 0, 0, 0);
      chk(s_a == 10, "R4 readback", s_a, 10);
      chk(s_b == 13, "R4 readback", s_b, 13);

      // R7: empty list blocks allocation without change
      chk(s_stall == 1, "R7 empty", s_stall, 1);
      step(1, 0, 1, 1, 2, 0, 0);
      chk(s_fire == 0, "R7 blocked", s_fire, 0);
      step(1, 2, 2, 0, 0, 0, 0);
      chk(s_a == 10, "R7 map unchanged", s_a, 10);
      chk(s_fire == 1, "R8 no-dest fires while empty", s_fire, 1);
      step(0, 0, 0, 0, 0, 0, 0);
      chk(s_stall == 1, "R8 list untouched", s_stall, 1);

      // R10/R6: release into empty list, then ordered reuse
      begin
         int t0, t1;
         t0 = hold_q.pop_front(); t1 = hold_q.pop_front();
         step(1, 0, 0, 1, 3, 1, t0);
         chk(s_stall == 1 && s_fire == 0, "R10 not same cycle", s_fire, 0);
         step(0, 0, 0, 0, 0, 1, t1);
         chk(s_stall == 0, "R10 unstall", s_stall, 0);
         step(1, 3, 4, 1, 3, 0, 0);
         chk(s_dst == t0, "R6 first released", s_dst, t0);
         step(1, 4, 3, 1, 4, 0, 0);
         chk(s_dst == t1, "R6 second released", s_dst, t1);
         chk(s_b == t0, "R4 new mapping visible", s_b, t0);
      end

      // random phase with shuffled release order
      for (int c = 0; c < 3000; c++) begin
         bit v, de, rv;
         int rt, pick;
         v  = ($urandom % 4) != 0;
         de = ($urandom % 3) != 0;
         rv = (hold_q.size() > 0) && (($urandom % 2) == 0);
         rt = 0;
         if (rv) begin
            pick = $urandom % hold_q.size();
            rt = hold_q[pick];
            hold_q.delete(pick);
         end
         step(v, $urandom % 8, $urandom % 8, de, $urandom % 8, rv, rt);
      end

      summary();
      $finish;
   end
endmodule